// File: doc/BRIEF.md
# Punctured Convolutional Encoder with Serial Output

This block takes a stream of single data bits and runs each one through a rate-1/2 convolutional encoder. The constraint length and the two generator codes are parameters. The encoder's output pairs are grouped by position within a puncture group of `N` input bits. Two `N`-bit keep-masks decide which bits of each pair survive. The surviving `M` bits of every group leave on a one-bit serial output, one bit per enabled clock. Since `M` is larger than `N`, the block throttles its input. After the last bit of a group is accepted, `in_ready` falls for `M-N` enabled cycles, and the serial drain keeps pace with the input side.

The input side is a valid/ready stream. A bit transfers on an enabled edge where `in_valid` and `in_ready` are both high. A producer that holds `in_valid` with `in_ready` low simply waits, and nothing is sampled. A first-of-group flag travels with each transfer and realigns the puncture pattern. The output side has no back-pressure: `out_valid` marks each meaningful `out_bit`, and the consumer must take every bit it flags. The output is one group late. The first flagged block after reset is all zeros, and each later block carries the group that completed before it.

Top module: `conv_punct_ser_enc`

## Requirements
- R1: Each accepted bit shifts into a `K`-bit register at tap 0, and the older taps move up by one. The pair bits are c0 = XOR of (register AND `GEN0`) and c1 = XOR of (register AND `GEN1`), taken on the register that already includes the new bit. The register resets to zero and changes only on an accepted bit.
- R2: A group position `j` counts from 0. `KEEP0[j]`=1 keeps c0 and `KEEP1[j]`=1 keeps c1, with bit 0 of each mask being position 0. The serial order is position 0 upward, and within a position c0 goes before c1.
- R3: The accept that completes a group (position `N-1`) drives `in_ready` low for exactly `M-N` enabled cycles. `in_valid` offered while `in_ready` is low transfers nothing.
- R4: When a group completes, `out_valid` goes high on the next cycle and stays high for `M` enabled cycles, presenting one kept bit per cycle.
- R5: The first output block after reset is `M` zeros. Output block k+1 carries the punctured bits of input group k.
- R6: An accepted bit with `in_first`=1 realigns the pattern, but only if the previously accepted bit had `in_first`=0. That bit becomes position 0, and a partly collected group is discarded without being emitted. A flag held over several accepts realigns only once.
- R7: `first_ready` is high exactly when the pattern is at position 0 and `in_ready` is high. It is low on the cycle after a realigning accept.
- R8: While `ce` is low, every input other than `srst` is ignored and no state or output changes.
- R9: `srst` clears all state on each edge it is high, whatever `ce` is. No bit is accepted during reset, even though `in_ready` may read high.
- R10: Parameters are checked when the design is elaborated. Constraint length must be 3..9, `N` must be 2..12, `M` must lie in `N+1..2N-1`, and the total count of ones in the two masks must equal `M`. Each group then yields exactly `M` output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| srst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; low freezes the block |
| in_valid | input | 1 | Input bit offered |
| in_data | input | 1 | Input bit |
| in_first | input | 1 | Marks the offered bit as position 0 of a puncture group |
| in_ready | output | 1 | Block can take a bit this cycle |
| first_ready | output | 1 | Pattern is at a group boundary; a realign is clean now |
| out_valid | output | 1 | `out_bit` carries a kept encoded bit |
| out_bit | output | 1 | Serial punctured output |

## Verification
The assertions assume that `srst` is high from the first edge and that `in_valid`, `in_data`, `in_first` and `ce` are never unknown while out of reset. They also assume that the consumer takes every flagged output bit, since the drain cannot be stalled. The stimulus drives every input to a known 0 or 1 from time zero, using a fixed seed. It mixes runs of full-rate input, sparse valids, `ce` held low and realign flags both pulsed and held. It never leaves an input floating.

// File: rtl/conv_punct_pkg.sv
package conv_punct_pkg;

  typedef struct packed {
    logic c1;
    logic c0;
  } enc_pair_t;

  function automatic int ones_in(logic [31:0] a);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(a[i]);
    return n;
  endfunction

  // Number of kept bits in positions strictly below pos (both masks).
  function automatic int kept_before(logic [31:0] k0, logic [31:0] k1, int pos);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (i < pos) n += int'(k0[i]) + int'(k1[i]);
    end
    return n;
  endfunction

endpackage

// File: rtl/conv_core.sv
module conv_core
  import conv_punct_pkg::*;
#(
  parameter int             K    = 7,
  parameter logic [K-1:0]   GEN0 = 7'b1111001,
  parameter logic [K-1:0]   GEN1 = 7'b1011011
) (
  input  logic      clk,
  input  logic      srst,
  input  logic      accept,
  input  logic      din,
  output enc_pair_t pair
);

  logic [K-1:0] sr_q;
  logic [K-1:0] sr_n;

  assign sr_n    = {sr_q[K-2:0], din};
  assign pair.c0 = ^(sr_n & GEN0);
  assign pair.c1 = ^(sr_n & GEN1);

  always_ff @(posedge clk) begin
    if (srst)        sr_q <= '0;
    else if (accept) sr_q <= sr_n;
  end

  // R1: register moves only on an accepted bit
  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (srst)
    !accept |=> $stable(sr_q));

endmodule

// File: rtl/punct_ctrl.sv
module punct_ctrl
  import conv_punct_pkg::*;
#(
  parameter int           N     = 3,
  parameter int           M     = 4,
  parameter logic [N-1:0] KEEP0 = 3'b101,
  parameter logic [N-1:0] KEEP1 = 3'b011
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         ce,
  input  logic         in_valid,
  input  logic         in_first,
  input  enc_pair_t    pair,
  output logic         accept,
  output logic         in_ready,
  output logic         first_ready,
  output logic         load,
  output logic [M-1:0] load_data
);

  localparam int PW    = $clog2(N);
  localparam int STALL = M - N;
  localparam int SW    = $clog2(STALL + 1);

  logic [PW-1:0] pos_q;
  logic [SW-1:0] stall_q;
  logic          fdp_q;
  logic [N-1:0]  g0_q, g1_q, g0_n, g1_n;
  logic [N-1:0]  h0_q, h1_q;
  logic          realign;
  logic [PW-1:0] eff_pos;

  assign in_ready    = (stall_q == '0);
  assign first_ready = in_ready && (pos_q == '0);
  assign accept      = ce && in_valid && in_ready && !srst;
  assign realign     = accept && in_first && !fdp_q;
  assign eff_pos     = realign ? '0 : pos_q;
  assign load        = accept && (eff_pos == PW'(N - 1));

  always_comb begin
    g0_n = g0_q;
    g1_n = g1_q;
    if (accept) begin
      g0_n[eff_pos] = pair.c0;
      g1_n[eff_pos] = pair.c1;
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      pos_q   <= '0;
      stall_q <= '0;
      fdp_q   <= 1'b0;
      g0_q    <= '0;
      g1_q    <= '0;
      h0_q    <= '0;
      h1_q    <= '0;
    end else if (ce) begin
      if (stall_q != '0) stall_q <= stall_q - 1'b1;
      if (accept) begin
        fdp_q <= in_first;
        g0_q  <= g0_n;
        g1_q  <= g1_n;
        if (load) begin
          pos_q   <= '0;
          stall_q <= SW'(STALL);
          h0_q    <= g0_n;
          h1_q    <= g1_n;
        end else begin
          pos_q <= eff_pos + 1'b1;
        end
      end
    end
  end

  // Pack the held group's kept bits: position order, c0 before c1.
  for (genvar j = 0; j < N; j++) begin : g_pack
    localparam int BASE = kept_before(32'(KEEP0), 32'(KEEP1), j);
    if (KEEP0[j]) begin : g_k0
      assign load_data[BASE] = h0_q[j];
    end
    if (KEEP1[j]) begin : g_k1
      assign load_data[BASE + int'(KEEP0[j])] = h1_q[j];
    end
  end

  // R3: completing a group closes the input next cycle
  a_r3_ready_drop: assert property (@(posedge clk) disable iff (srst)
    load |=> !in_ready);

  // R7: a realign leaves the group boundary
  a_r7_first_drop: assert property (@(posedge clk) disable iff (srst)
    realign |=> !first_ready);

  // R9: reset returns the pattern to a clean boundary
  a_r9_reset_clean: assert property (@(posedge clk)
    srst |=> (first_ready && in_ready));

endmodule

// File: rtl/punct_serializer.sv
module punct_serializer #(
  parameter int M = 4
) (
  input  logic         clk,
  input  logic         srst,
  input  logic         ce,
  input  logic         load,
  input  logic [M-1:0] load_data,
  output logic         out_valid,
  output logic         out_bit
);

  localparam int CW = $clog2(M + 1);

  logic [CW-1:0] cnt_q;
  logic [M-1:0]  sh_q;

  assign out_valid = (cnt_q != '0);
  assign out_bit   = sh_q[0];

  always_ff @(posedge clk) begin
    if (srst) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (load) begin
      cnt_q <= CW'(M);
      sh_q  <= load_data;
    end else if (ce && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      sh_q  <= sh_q >> 1;
    end
  end

  // R4: a new block never cuts into an unfinished one
  a_r4_no_overrun: assert property (@(posedge clk) disable iff (srst)
    load |-> (cnt_q <= CW'(1)));

  // R8: disabled clock freezes the drain
  a_r8_freeze: assert property (@(posedge clk) disable iff (srst)
    !ce |=> ($stable(cnt_q) && $stable(sh_q)));

endmodule

// File: rtl/conv_punct_ser_enc.sv
module conv_punct_ser_enc
  import conv_punct_pkg::*;
#(
  parameter int           K     = 7,
  parameter logic [K-1:0] GEN0  = 7'b1111001,
  parameter logic [K-1:0] GEN1  = 7'b1011011,
  parameter int           N     = 3,
  parameter int           M     = 4,
  parameter logic [N-1:0] KEEP0 = 3'b101,
  parameter logic [N-1:0] KEEP1 = 3'b011
) (
  input  logic clk,
  input  logic srst,
  input  logic ce,
  input  logic in_valid,
  input  logic in_data,
  input  logic in_first,
  output logic in_ready,
  output logic first_ready,
  output logic out_valid,
  output logic out_bit
);

  localparam int KEPT = ones_in(32'(KEEP0)) + ones_in(32'(KEEP1));

  enc_pair_t    pair;
  logic         accept;
  logic         load;
  logic [M-1:0] load_data;

  conv_core #(.K(K), .GEN0(GEN0), .GEN1(GEN1)) u_core (
    .clk    (clk),
    .srst   (srst),
    .accept (accept),
    .din    (in_data),
    .pair   (pair)
  );

  punct_ctrl #(.N(N), .M(M), .KEEP0(KEEP0), .KEEP1(KEEP1)) u_ctrl (
    .clk         (clk),
    .srst        (srst),
    .ce          (ce),
    .in_valid    (in_valid),
    .in_first    (in_first),
    .pair        (pair),
    .accept      (accept),
    .in_ready    (in_ready),
    .first_ready (first_ready),
    .load        (load),
    .load_data   (load_data)
  );

  punct_serializer #(.M(M)) u_ser (
    .clk       (clk),
    .srst      (srst),
    .ce        (ce),
    .load      (load),
    .load_data (load_data),
    .out_valid (out_valid),
    .out_bit   (out_bit)
  );

  // R10: parameter consistency at elaboration
  initial begin
    a_r10_k_range: assert (K >= 3 && K <= 9)
      else $error("constraint length out of range");
    a_r10_n_range: assert (N >= 2 && N <= 12)
      else $error("group length out of range");
    a_r10_m_range: assert (M >= N + 1 && M <= 2 * N - 1)
      else $error("output count out of range");
    a_r10_mask_ones: assert (KEPT == M)
      else $error("mask ones do not match output count");
  end

  // R3: input stalls only while a block is draining
  a_r3_stall_in_drain: assert property (@(posedge clk) disable iff (srst)
    !in_ready |-> out_valid);

endmodule

// File: tb/tb_conv_punct_ser_enc.sv
module tb_conv_punct_ser_enc;

  localparam int           K     = 7;
  localparam logic [K-1:0] GEN0  = 7'b1111001;
  localparam logic [K-1:0] GEN1  = 7'b1011011;
  localparam int           N     = 3;
  localparam int           M     = 4;
  localparam logic [N-1:0] KEEP0 = 3'b101;
  localparam logic [N-1:0] KEEP1 = 3'b011;

  logic clk = 1'b0;
  logic r_srst = 1'b1, r_ce = 1'b1, r_v = 1'b0, r_d = 1'b0, r_f = 1'b0;
  logic in_ready, first_ready, out_valid, out_bit;

  always #4 clk = ~clk;

  conv_punct_ser_enc #(.K(K), .GEN0(GEN0), .GEN1(GEN1), .N(N), .M(M),
                       .KEEP0(KEEP0), .KEEP1(KEEP1)) dut (
    .clk(clk), .srst(r_srst), .ce(r_ce), .in_valid(r_v), .in_data(r_d),
    .in_first(r_f), .in_ready(in_ready), .first_ready(first_ready),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  int    n_run = 0, n_fail = 0;
  bit    done = 0;
  string cur_tag = "R9";

  // reference state
  logic [K-1:0] m_sr;
  int           m_pos, m_stall, m_cnt;
  logic         m_fdp, m_acc;
  logic [N-1:0] m_g0, m_g1, m_h0, m_h1;
  logic [M-1:0] m_sh;

  // capture
  int   vcount = 0;
  logic cap [0:M-1];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [M-1:0] pack_kept(logic [N-1:0] a, logic [N-1:0] b);
    logic [M-1:0] r;
    int idx;
    r = '0;
    idx = 0;
    for (int j = 0; j < N; j++) begin
      if (KEEP0[j]) begin r[idx] = a[j]; idx++; end
      if (KEEP1[j]) begin r[idx] = b[j]; idx++; end
    end
    return r;
  endfunction

  task automatic model(logic s, logic c, logic v, logic d, logic f);
    logic ld, fdt;
    int   p;
    m_acc = 0;
    if (s) begin
      m_sr = '0; m_pos = 0; m_stall = 0; m_cnt = 0; m_fdp = 0;
      m_g0 = '0; m_g1 = '0; m_h0 = '0; m_h1 = '0; m_sh = '0;
      return;
    end
    if (!c) return;
    ld = 0;
    m_acc = v && (m_stall == 0);
    if (m_stall != 0) m_stall--;
    if (m_acc) begin
      m_sr = {m_sr[K-2:0], d};
      fdt = f && !m_fdp;
      m_fdp = f;
      p = fdt ? 0 : m_pos;
      m_g0[p] = ^(m_sr & GEN0);
      m_g1[p] = ^(m_sr & GEN1);
      if (p == N - 1) begin
        m_sh = pack_kept(m_h0, m_h1);
        m_h0 = m_g0; m_h1 = m_g1;
        m_pos = 0; m_stall = M - N; ld = 1;
      end else m_pos = p + 1;
    end
    if (ld) m_cnt = M;
    else if (m_cnt != 0 && !ld) begin
      if (!(m_acc && ld)) begin m_sh = m_sh >> 1; m_cnt--; end
    end
  endtask

  task automatic compare();
    check(in_ready == (m_stall == 0), "R3", "in_ready", in_ready, m_stall == 0);
    check(first_ready == (m_stall == 0 && m_pos == 0), "R7", "first_ready",
          first_ready, m_stall == 0 && m_pos == 0);
    check(out_valid == (m_cnt != 0), "R4", "out_valid", out_valid, m_cnt != 0);
    if (m_cnt != 0)
      check(out_bit == m_sh[0], cur_tag, "out_bit R1 R2", out_bit, m_sh[0]);
    if (out_valid) begin
      if (vcount < M) cap[vcount] = out_bit;
      vcount++;
    end
  endtask

  task automatic cyc(logic s, logic c, logic v, logic d, logic f);
    r_srst = s; r_ce = c; r_v = v; r_d = d; r_f = f;
    model(s, c, v, d, f);
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int acc;
    logic p_rdy, p_ov, p_ob;
    void'($urandom(32'd20240611));

    // R9: reset with valid offered
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 0);
    check(in_ready && first_ready && !out_valid, "R9", "reset state",
          {in_ready, first_ready, out_valid}, 3'b110);

    // R5 / R10: four full-rate groups from reset
    cur_tag = "R1 R2 R5";
    vcount = 0;
    acc = 0;
    while (acc < 4 * N) begin
      cyc(0, 1, 1, 1'($urandom), 0);
      if (m_acc) acc++;
    end
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, 0, 0);
    check(vcount == 4 * M, "R10 R4", "kept bits for four groups", vcount, 4 * M);
    for (int i = 0; i < M; i++)
      check(cap[i] == 1'b0, "R5", "first block bit", cap[i], 0);

    // random mix
    cur_tag = "R1 R2 R3 R4 R6 R8";
    for (int i = 0; i < 1500; i++)
      cyc(0, ($urandom % 100) < 85, ($urandom % 100) < 75,
          1'($urandom), ($urandom % 100) < 6);

    // R6 / R7: realign mid-group, then held flag
    cur_tag = "R6 R7";
    while (!(in_ready && m_pos == 1)) cyc(0, 1, 1, 1'($urandom), 0);
    cyc(0, 1, 1, 1, 1);
    check(!first_ready && m_pos == 1, "R6 R7", "realign to position 0",
          first_ready, 0);
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, 1'($urandom), 1);
    for (int i = 0; i < 20; i++) cyc(0, 1, 1, 1'($urandom), 0);

    // R8: clock enable low
    cur_tag = "R8";
    while (!out_valid) cyc(0, 1, 1, 1'($urandom), 0);
    p_rdy = in_ready; p_ov = out_valid; p_ob = out_bit;
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 1, 1'($urandom), 1);
      check(in_ready == p_rdy && out_valid == p_ov && out_bit == p_ob, "R8",
            "frozen outputs", {in_ready, out_valid, out_bit}, {p_rdy, p_ov, p_ob});
    end
    for (int i = 0; i < 20; i++) cyc(0, 1, ($urandom % 2) == 0, 1'($urandom), 0);

    // R9: reset mid-run, with and without enable
    cur_tag = "R9";
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 17; i++)
        cyc(0, 1, ($urandom % 100) < 80, 1'($urandom), ($urandom % 100) < 5);
      cyc(1, r[0], 1, 1, 0);
      cyc(1, 1, 1, 1, 1);
      check(!out_valid && in_ready && first_ready, "R9", "mid-run reset",
            {out_valid, in_ready, first_ready}, 3'b011);
    end
    for (int i = 0; i < 40; i++) cyc(0, 1, 1, 1'($urandom), 0);

    finish_run();
  end

endmodule